// File: doc/BRIEF.md
# Byte ALU with Operand Steering

This block is the arithmetic and logic stage of a small accumulator-style processor core. Two four-way multiplexers sit in front of an eight-bit ALU. They pick each operand from these sources: the working register, the value read from the register file, the instruction literal, and a fourth source that differs per side. On the A side the fourth source is a one-hot bit mask whose polarity can be flipped. On the B side it is the constant one.

With these choices the instruction set needs no dedicated hardware for its bit and step operations:
- Setting a bit is an OR of the bus value with the plain mask.
- Clearing a bit is an AND of the bus value with the inverted mask.
- Increment and decrement reuse the adder with B fixed at one.

An external instruction decoder drives the selects, the operation code, the bit position and the mask polarity. The incoming carry comes from the flag register, which sits outside this block. The block is purely combinational. It returns the result together with a zero flag and a new carry flag.

Top module: `byte_alu_steer`

## Requirements
- R1: Operand A is selected by `a_sel`: 00 picks `w_reg`, 01 picks `bus_val`, 10 picks `lit_val`, and 11 picks the bit mask.
- R2: Operand B is selected by `b_sel`: 00 picks `w_reg`, 01 picks `bus_val`, 10 picks `lit_val`, and 11 picks the constant 1.
- R3: The bit mask has exactly one bit set, at index `bit_pos`, where index 0 is the LSB. When `mask_inv` is 1, the whole mask is inverted bitwise.
- R4: Op 0000 (add) returns (A+B) mod 256. Its carry output is 1 exactly when A+B exceeds 255.
- R5: Op 1000 (subtract) returns (A-B) mod 256. Its carry output is 1 exactly when A >= B, meaning no borrow occurred.
- R6: Op 0001 returns A AND B, op 0010 returns A OR B, and op 0011 returns A XOR B. For all three, the carry output equals `carry_in`.
- R7: Op 0100 (complement) returns the bitwise inverse of A. The carry output equals `carry_in`.
- R8: Op 0101 rotates A right through the carry. `carry_in` enters bit 7, and bit 0 of A becomes the carry output.
- R9: Op 0110 rotates A left through the carry. `carry_in` enters bit 0, and bit 7 of A becomes the carry output.
- R10: Op 0111 exchanges the upper and lower nibbles of A. The carry output equals `carry_in`.
- R11: `zero_out` is 1 exactly when the 8-bit result is zero, for every operation.
- R12: Op codes 1001 through 1111 return a result of zero, and the carry output equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_reg | input | 8 | Working register value |
| bus_val | input | 8 | Value read from the register file |
| lit_val | input | 8 | Instruction literal |
| bit_pos | input | 3 | Index of the mask bit |
| mask_inv | input | 1 | Invert the bit mask when 1 |
| a_sel | input | 2 | Operand A source select |
| b_sel | input | 2 | Operand B source select |
| op_code | input | 4 | ALU operation |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | ALU result |
| zero_out | output | 1 | Result-is-zero flag |
| carry_out | output | 1 | New carry flag |

## Verification
The deferred assertions check several properties on every input change:
- The mask carries a single active bit at `bit_pos`.
- The subtract carry tracks A >= B.
- Add matches a widened sum.
- The rotate carries take the correct end bit.
- Swap places the low nibble on top.
- Undefined op codes give a zero result and pass the carry through.
- The literal and constant-one selects reach the operands.

Other behaviours depend on a whole instruction idiom, and only the bench scenarios show them. These are:
- setting and clearing a bit at each position;
- increment and decrement wrapping at the ends of the byte range;
- the zero flag across the sweep of every operation.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_AND  = 4'b0001,
    OP_OR   = 4'b0010,
    OP_XOR  = 4'b0011,
    OP_COM  = 4'b0100,
    OP_ROR  = 4'b0101,
    OP_ROL  = 4'b0110,
    OP_SWAP = 4'b0111,
    OP_SUB  = 4'b1000
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_W    = 2'b00,
    SRC_BUS  = 2'b01,
    SRC_LIT  = 2'b10,
    SRC_AUX  = 2'b11
  } src_sel_e;

endpackage

// File: rtl/operand_mux.sv
module operand_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] w_src,
  input  logic [W-1:0] bus_src,
  input  logic [W-1:0] lit_src,
  input  logic [W-1:0] aux_src,
  input  logic [1:0]   sel,
  output logic [W-1:0] operand
);
  import byte_alu_pkg::*;

  always_comb begin
    unique case (src_sel_e'(sel))
      SRC_W:   operand = w_src;
      SRC_BUS: operand = bus_src;
      SRC_LIT: operand = lit_src;
      default: operand = aux_src;
    endcase
  end
endmodule

// File: rtl/bit_mask_gen.sv
module bit_mask_gen #(
  parameter int W = 8,
  localparam int POS_W = $clog2(W)
) (
  input  logic [POS_W-1:0] pos,
  input  logic             invert,
  output logic [W-1:0]     mask
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] raw_mask;

  assign raw_mask = ONE << pos;
  assign mask     = invert ? ~raw_mask : raw_mask;

  // R3: one active bit, at pos, with the chosen polarity
  always_comb begin
    assert_mask_onehot_R3: assert final (($countones(mask ^ {W{invert}}) == 1) && (mask[pos] != invert))
      else $error("mask %b pos %0d inv %b", mask, pos, invert);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [3:0]   op,
  input  logic         c_in,
  output logic [W-1:0] r_out,
  output logic         c_out
);
  import byte_alu_pkg::*;

  localparam int HALF = W / 2;

  function automatic logic [W:0] add_carry(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  function automatic logic [W-1:0] nibble_swap(input logic [W-1:0] x);
    return {x[HALF-1:0], x[W-1:HALF]};
  endfunction

  // internal events brought out for checking
  logic [W:0] sum_add;
  logic [W:0] sum_sub;
  logic       op_is_known;

  assign sum_add = add_carry(a_in, b_in, 1'b0);
  assign sum_sub = add_carry(a_in, ~b_in, 1'b1);
  assign op_is_known = (op[3] == 1'b0) || (op == OP_SUB);

  always_comb begin
    r_out = '0;
    c_out = c_in;
    case (alu_op_e'(op))
      OP_ADD:  {c_out, r_out} = sum_add;
      OP_SUB:  {c_out, r_out} = sum_sub;
      OP_AND:  r_out = a_in & b_in;
      OP_OR:   r_out = a_in | b_in;
      OP_XOR:  r_out = a_in ^ b_in;
      OP_COM:  r_out = ~a_in;
      OP_ROR:  begin r_out = {c_in, a_in[W-1:1]}; c_out = a_in[0];   end
      OP_ROL:  begin r_out = {a_in[W-2:0], c_in}; c_out = a_in[W-1]; end
      OP_SWAP: r_out = nibble_swap(a_in);
      default: begin r_out = '0; c_out = c_in; end
    endcase
  end

  always_comb begin
    if (op == OP_ADD) begin
      assert_add_wide_R4: assert final ((int'(r_out) + (c_out ? (1 << W) : 0)) == (int'(a_in) + int'(b_in)))
        else $error("add mismatch");
    end
    if (op == OP_SUB) begin
      assert_sub_noborrow_R5: assert final (c_out == (a_in >= b_in))
        else $error("sub carry mismatch");
    end
    if (op == OP_ROR) begin
      assert_ror_ends_R8: assert final ((c_out == a_in[0]) && (r_out[W-1] == c_in))
        else $error("ror mismatch");
    end
    if (op == OP_ROL) begin
      assert_rol_ends_R9: assert final ((c_out == a_in[W-1]) && (r_out[0] == c_in))
        else $error("rol mismatch");
    end
    if (op == OP_SWAP) begin
      assert_swap_halves_R10: assert final ((r_out[W-1:HALF] == a_in[HALF-1:0]) && (c_out == c_in))
        else $error("swap mismatch");
    end
    if (!op_is_known) begin
      assert_undef_quiet_R12: assert final ((r_out == '0) && (c_out == c_in))
        else $error("undefined op not quiet");
    end
  end
endmodule

// File: rtl/byte_alu_steer.sv
module byte_alu_steer #(
  parameter int W = 8,
  localparam int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     w_reg,
  input  logic [W-1:0]     bus_val,
  input  logic [W-1:0]     lit_val,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             mask_inv,
  input  logic [1:0]       a_sel,
  input  logic [1:0]       b_sel,
  input  logic [3:0]       op_code,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             zero_out,
  output logic             carry_out
);
  localparam logic [W-1:0] CONST_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] bit_mask;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;

  bit_mask_gen #(.W(W)) mask_i (
    .pos(bit_pos), .invert(mask_inv), .mask(bit_mask)
  );

  operand_mux #(.W(W)) mux_a_i (
    .w_src(w_reg), .bus_src(bus_val), .lit_src(lit_val), .aux_src(bit_mask),
    .sel(a_sel), .operand(opnd_a)
  );

  operand_mux #(.W(W)) mux_b_i (
    .w_src(w_reg), .bus_src(bus_val), .lit_src(lit_val), .aux_src(CONST_ONE),
    .sel(b_sel), .operand(opnd_b)
  );

  alu_core #(.W(W)) core_i (
    .a_in(opnd_a), .b_in(opnd_b), .op(op_code), .c_in(carry_in),
    .r_out(result), .c_out(carry_out)
  );

  assign zero_out = (result == '0);

  always_comb begin
    if (a_sel == 2'b10) begin
      assert_a_literal_R1: assert final (opnd_a == lit_val) else $error("A literal select");
    end
    if (b_sel == 2'b11) begin
      assert_b_const_R2: assert final (opnd_b == CONST_ONE) else $error("B constant select");
    end
  end
endmodule

// File: tb/byte_alu_steer_tb_top.sv
module byte_alu_steer_tb_top;
  logic       clk = 1'b0;
  logic [7:0] w_reg = '0, bus_val = '0, lit_val = '0;
  logic [2:0] bit_pos = '0;
  logic       mask_inv = 1'b0;
  logic [1:0] a_sel = '0, b_sel = '0;
  logic [3:0] op_code = '0;
  logic       carry_in = 1'b0;
  logic [7:0] result;
  logic       zero_out, carry_out;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  byte_alu_steer dut_i (
    .w_reg(w_reg), .bus_val(bus_val), .lit_val(lit_val), .bit_pos(bit_pos),
    .mask_inv(mask_inv), .a_sel(a_sel), .b_sel(b_sel), .op_code(op_code),
    .carry_in(carry_in), .result(result), .zero_out(zero_out), .carry_out(carry_out)
  );

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d (op %0d)", req, got, exp, op_code);
    end
  endtask

  task automatic model(input int op, input int a, input int b, input int ci,
                       output int r, output int c);
    c = ci;
    r = 0;
    case (op)
      0: begin r = (a + b) % 256; c = (a + b > 255) ? 1 : 0; end
      8: begin r = (a - b + 256) % 256; c = (a >= b) ? 1 : 0; end
      1: r = a & b;
      2: r = a | b;
      3: r = a ^ b;
      4: r = 255 - a;
      5: begin r = a / 2 + ci * 128; c = a % 2; end
      6: begin r = (a * 2) % 256 + ci; c = (a >= 128) ? 1 : 0; end
      7: r = (a % 16) * 16 + a / 16;
      default: begin r = 0; c = ci; end
    endcase
  endtask

  function automatic string op_req(input int op);
    case (op)
      0: return "R4";
      8: return "R5";
      1, 2, 3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      7: return "R10";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int r, c;
    #2;
    // initial state: all-zero inputs give ADD of W with W
    check("R11 initial zero", int'(zero_out), 1);
    check("R4 initial result", int'(result), 0);

    // R1 / R2: each select combination with ADD
    w_reg = 8'd3; bus_val = 8'd20; lit_val = 8'd100; bit_pos = 3'd4; mask_inv = 1'b0;
    op_code = 4'b0000; carry_in = 1'b0;
    for (int sa = 0; sa < 4; sa++) begin
      for (int sb = 0; sb < 4; sb++) begin
        int va, vb;
        a_sel = 2'(sa); b_sel = 2'(sb);
        va = (sa == 0) ? 3 : (sa == 1) ? 20 : (sa == 2) ? 100 : 16;
        vb = (sb == 0) ? 3 : (sb == 1) ? 20 : (sb == 2) ? 100 : 1;
        #2;
        check(sb == 3 ? "R2 const one" : "R1 R2 select", int'(result), (va + vb) % 256);
      end
    end

    // R3: bit set and bit clear at every position
    a_sel = 2'b11; b_sel = 2'b01;
    for (int p = 0; p < 8; p++) begin
      bit_pos = 3'(p);
      bus_val = 8'h00; mask_inv = 1'b0; op_code = 4'b0010; #2;
      check("R3 set bit", int'(result), 1 << p);
      bus_val = 8'hFF; mask_inv = 1'b1; op_code = 4'b0001; #2;
      check("R3 clear bit", int'(result), 255 - (1 << p));
      bus_val = 8'h5A; mask_inv = 1'b0; op_code = 4'b0011; #2;
      check("R3 toggle bit", int'(result), 8'h5A ^ (1 << p));
    end

    // R4 / R5: increment and decrement wrap
    a_sel = 2'b01; b_sel = 2'b11;
    bus_val = 8'hFF; op_code = 4'b0000; #2;
    check("R4 inc wrap result", int'(result), 0);
    check("R4 inc wrap carry", int'(carry_out), 1);
    check("R11 inc wrap zero", int'(zero_out), 1);
    bus_val = 8'h00; op_code = 4'b1000; #2;
    check("R5 dec wrap result", int'(result), 255);
    check("R5 dec borrow carry", int'(carry_out), 0);
    bus_val = 8'h01; #2;
    check("R5 dec to zero carry", int'(carry_out), 1);
    check("R11 dec to zero", int'(zero_out), 1);

    // sweep of every op code: A from bus, B from literal
    a_sel = 2'b01; b_sel = 2'b10; w_reg = 8'hC3;
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += 37) begin
          for (int ci = 0; ci < 2; ci++) begin
            op_code = 4'(op); bus_val = 8'(a); lit_val = 8'(b); carry_in = ci[0];
            #2;
            model(op, a, b, ci, r, c);
            check(op_req(op), int'(result), r);
            check(op_req(op), int'(carry_out), c);
            check("R11 zero flag", int'(zero_out), (r == 0) ? 1 : 0);
          end
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule